// File: doc/BRIEF.md
# Masked Vectored Interrupt Controller

This block collects level-sensitive interrupt lines from peripherals and presents them to a processor core as three signals: an interrupt request, an 8-bit vector and a separate non-maskable interrupt. Ordinary lines are filtered by a software-written mask. The filtered set is then encoded into one vector. A lone active source yields a fixed base plus its bit index. Two or more simultaneous sources collapse onto one shared "multiple" vector, and the interrupt handler then decides priority in software.

The two highest-numbered lines skip the mask entirely. Each drives its own bit of an NMI status word, and any of them being high raises the non-maskable output. A small word-addressed register bank exposes the mask, the raw and the masked pending sets, and the NMI status over a synchronous read/write bus. Only the mask can be written.

Encoding is carried by a three-state classifier, whose next state is recomputed from the next-cycle masked set:
- IDLE: no masked source.
- SINGLE: exactly one masked source.
- MULTI: two or more masked sources.

The state may move between any pair of these states in one cycle. The transitions are named by their cause:
- raise: IDLE to SINGLE.
- burst: IDLE to MULTI.
- pile-up: SINGLE to MULTI.
- drain: MULTI to SINGLE.
- clear: SINGLE or MULTI to IDLE.

Top module: `masked_vec_intc`

## Requirements
- R1: After reset the mask, raw pending, masked pending and NMI status words all read 0, and `cpu_irq`, `cpu_nmi` and `cpu_vector` are 0.
- R2: A write to word 0 (byte address bits [5:2] equal 0) loads the mask from `bus_wdata`. Writes to any other word leave the mask and all outputs unchanged.
- R3: Input line n, for n from 1 to 29, appears at raw pending bit n-1 (word 1) and follows the line level with no latching. Line 0 has no effect. Raw pending bits 29 to 31 always read 0.
- R4: The masked pending word (word 2) always equals raw pending AND mask.
- R5: When exactly one masked bit i (0 to 30) is set, `cpu_vector` is 0x31 + i and `cpu_irq` is 1.
- R6: When two or more of masked bits 0 to 30 are set, `cpu_vector` is 0x30 and `cpu_irq` is 1.
- R7: With no masked bit set, `cpu_vector` is 0 and `cpu_irq` is 0. In every cycle, `cpu_irq` is 1 exactly when `cpu_vector` is non-zero.
- R8: Lines 30 and 31 set NMI status bits 30 and 31 (word 3) while high and clear them while low. `cpu_nmi` is the OR of those bits. These lines never change raw pending, the mask path or the vector.
- R9: A read returns data on `bus_rdata` one clock edge after it is issued. Word 4 and every word above 4 read as 0.
- R10: `cpu_irq`, `cpu_vector` and `cpu_nmi` take their new values on the first clock edge after a line change or a mask write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte address; bits [5:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one edge after `bus_rd` |
| irq_lines | input | 32 | Level-sensitive interrupt lines |
| cpu_irq | output | 1 | Interrupt request to the core |
| cpu_vector | output | 8 | Encoded interrupt vector |
| cpu_nmi | output | 1 | Non-maskable interrupt request |

## Verification
The bench builds the block with its default parameters: 32 lines, of which the top 2 are NMI lines, and a 6-bit byte address. With this size every individual line, every pair of ordinary lines and every one-hot mask can be swept in full, and the read decode can be exercised past word 4. A pseudo-random phase then mixes arbitrary mask and line patterns. For every step the bench predicts the raw, masked and NMI words and the expected vector arithmetically.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [1:0] {
        SRC_IDLE   = 2'd0,
        SRC_SINGLE = 2'd1,
        SRC_MULTI  = 2'd2
    } src_state_e;

    localparam int WORD_MASK   = 0;
    localparam int WORD_RAW    = 1;
    localparam int WORD_MASKED = 2;
    localparam int WORD_NMI    = 3;
    localparam int WORD_RSVD   = 4;

endpackage

// File: rtl/intc_line_router.sv
module intc_line_router #(
    parameter int NUM_LINES = 32,
    parameter int NMI_LINES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines,
    output logic [NUM_LINES-1:0] raw_d,
    output logic [NUM_LINES-1:0] raw_q,
    output logic [NUM_LINES-1:0] nmi_q,
    output logic                 nmi_out
);
    localparam int ORD_LINES = NUM_LINES - NMI_LINES;

    logic [NUM_LINES-1:0] nmi_d;
    logic                 unused_line0;

    assign unused_line0 = lines[0];

    // Ordinary line n lands on bit n-1; upper raw bits never set.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_route
        if (g < ORD_LINES - 1) begin : g_ord
            assign raw_d[g] = lines[g+1];
        end else begin : g_rzero
            assign raw_d[g] = 1'b0;
        end
        if (g >= ORD_LINES) begin : g_nmi
            assign nmi_d[g] = lines[g];
        end else begin : g_nzero
            assign nmi_d[g] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q   <= '0;
            nmi_q   <= '0;
            nmi_out <= 1'b0;
        end else begin
            raw_q   <= raw_d;
            nmi_q   <= nmi_d;
            nmi_out <= |nmi_d;
        end
    end

endmodule

// File: rtl/intc_regbank.sv
module intc_regbank #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] raw_q,
    input  logic [DATA_W-1:0] nmi_q,
    output logic [DATA_W-1:0] mask_d,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] rdata
);
    import intc_pkg::*;

    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] WD_MASK   = WORD_W'(WORD_MASK);
    localparam logic [WORD_W-1:0] WD_RAW    = WORD_W'(WORD_RAW);
    localparam logic [WORD_W-1:0] WD_MASKED = WORD_W'(WORD_MASKED);
    localparam logic [WORD_W-1:0] WD_NMI    = WORD_W'(WORD_NMI);

    logic [WORD_W-1:0] word;
    logic [1:0]        unused_byte;

    assign word        = addr[ADDR_W-1:2];
    assign unused_byte = addr[1:0];

    // Next mask seen by the encoder in the same cycle as the write.
    assign mask_d = (wr_en && word == WD_MASK) ? wdata : mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (word)
                WD_MASK:   rdata <= mask_q;
                WD_RAW:    rdata <= raw_q;
                WD_MASKED: rdata <= raw_q & mask_q;
                WD_NMI:    rdata <= nmi_q;
                default:   rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/intc_vec_encoder.sv
module intc_vec_encoder #(
    parameter int                ENC_BITS  = 31,
    parameter int                VEC_W     = 8,
    parameter logic [VEC_W-1:0]  VEC_MULTI = 8'h30,
    parameter logic [VEC_W-1:0]  VEC_BASE  = 8'h31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ENC_BITS-1:0] masked_d,
    output logic [VEC_W-1:0]    vec_q,
    output logic                irq
);
    import intc_pkg::*;

    localparam int IDX_W = (ENC_BITS > 1) ? $clog2(ENC_BITS) : 1;

    src_state_e         state_q, state_d;
    logic               seen, multi;
    logic [IDX_W-1:0]   idx;
    logic [VEC_W-1:0]   vec_d;

    // Scan: remember the first set bit, flag any second one.
    always_comb begin
        seen  = 1'b0;
        multi = 1'b0;
        idx   = '0;
        for (int i = 0; i < ENC_BITS; i++) begin
            if (masked_d[i]) begin
                if (seen) begin
                    multi = 1'b1;
                end else begin
                    seen = 1'b1;
                    idx  = IDX_W'(i);
                end
            end
        end
    end

    // Next-state: raise / burst / pile-up / drain / clear.
    always_comb begin
        if (multi) begin
            state_d = SRC_MULTI;
        end else if (seen) begin
            state_d = SRC_SINGLE;
        end else begin
            state_d = SRC_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SRC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_d)
            SRC_IDLE:   vec_d = '0;
            SRC_SINGLE: vec_d = VEC_BASE + VEC_W'(idx);
            SRC_MULTI:  vec_d = VEC_MULTI;
            default:    vec_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else begin
            vec_q <= vec_d;
        end
    end

    assign irq = (state_q != SRC_IDLE);

endmodule

// File: rtl/masked_vec_intc.sv
module masked_vec_intc #(
    parameter int               NUM_LINES = 32,
    parameter int               NMI_LINES = 2,
    parameter int               ADDR_W    = 6,
    parameter int               VEC_W     = 8,
    parameter logic [VEC_W-1:0] VEC_MULTI = 8'h30,
    parameter logic [VEC_W-1:0] VEC_BASE  = 8'h31
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    input  logic [NUM_LINES-1:0] irq_lines,
    output logic                 cpu_irq,
    output logic [VEC_W-1:0]     cpu_vector,
    output logic                 cpu_nmi
);
    localparam int DATA_W   = NUM_LINES;
    localparam int ENC_BITS = NUM_LINES - 1;

    logic [DATA_W-1:0] raw_d, raw_q, nmi_q;
    logic [DATA_W-1:0] mask_d, mask_q;
    logic [DATA_W-1:0] masked_d;
    logic              unused_msb;

    assign masked_d   = raw_d & mask_d;
    assign unused_msb = masked_d[DATA_W-1];

    intc_line_router #(
        .NUM_LINES (NUM_LINES),
        .NMI_LINES (NMI_LINES)
    ) u_router (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines   (irq_lines),
        .raw_d   (raw_d),
        .raw_q   (raw_q),
        .nmi_q   (nmi_q),
        .nmi_out (cpu_nmi)
    );

    intc_regbank #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .rd_en  (bus_rd),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .raw_q  (raw_q),
        .nmi_q  (nmi_q),
        .mask_d (mask_d),
        .mask_q (mask_q),
        .rdata  (bus_rdata)
    );

    intc_vec_encoder #(
        .ENC_BITS  (ENC_BITS),
        .VEC_W     (VEC_W),
        .VEC_MULTI (VEC_MULTI),
        .VEC_BASE  (VEC_BASE)
    ) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .masked_d (masked_d[ENC_BITS-1:0]),
        .vec_q    (cpu_vector),
        .irq      (cpu_irq)
    );

endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
    parameter int               NUM_LINES = 32,
    parameter int               NMI_LINES = 2,
    parameter int               ADDR_W    = 6,
    parameter int               VEC_W     = 8,
    parameter logic [VEC_W-1:0] VEC_MULTI = 8'h30
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic                 cpu_irq,
    input logic [VEC_W-1:0]     cpu_vector,
    input logic                 cpu_nmi,
    input logic [NUM_LINES-1:0] mask_q,
    input logic [NUM_LINES-1:0] masked_d
);
    localparam int ORD_LINES = NUM_LINES - NMI_LINES;
    localparam int ENC_BITS  = NUM_LINES - 1;

    a_r7_irq_vs_vector: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == (cpu_vector != '0));

    a_r5_single_vector: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $countones($past(masked_d[ENC_BITS-1:0])) == 1)
        |-> (cpu_vector > VEC_MULTI));

    a_r6_multi_vector: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $countones($past(masked_d[ENC_BITS-1:0])) > 1)
        |-> (cpu_vector == VEC_MULTI));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $countones($past(masked_d[ENC_BITS-1:0])) == 0)
        |-> !cpu_irq);

    a_r8_nmi_or: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cpu_nmi == (|$past(irq_lines[NUM_LINES-1:ORD_LINES]))));

    a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(bus_wr) && $past(bus_addr[ADDR_W-1:2]) == '0))
        |-> $stable(mask_q));

endmodule

bind masked_vec_intc intc_checker #(
    .NUM_LINES (NUM_LINES),
    .NMI_LINES (NMI_LINES),
    .ADDR_W    (ADDR_W),
    .VEC_W     (VEC_W),
    .VEC_MULTI (VEC_MULTI)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .irq_lines  (irq_lines),
    .cpu_irq    (cpu_irq),
    .cpu_vector (cpu_vector),
    .cpu_nmi    (cpu_nmi),
    .mask_q     (mask_q),
    .masked_d   (masked_d)
);

// File: tb/tb_masked_vec_intc.sv
module tb_masked_vec_intc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_lines = '0;
    logic        cpu_irq;
    logic [7:0]  cpu_vector;
    logic        cpu_nmi;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [31:0] cur_mask = '0;
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    masked_vec_intc dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_lines  (irq_lines),
        .cpu_irq    (cpu_irq),
        .cpu_vector (cpu_vector),
        .cpu_nmi    (cpu_nmi)
    );

    function automatic logic [31:0] m_raw(input logic [31:0] l);
        logic [31:0] r = '0;
        for (int n = 1; n < 30; n++) r[n-1] = l[n];
        return r;
    endfunction

    function automatic logic [7:0] m_vec(input logic [31:0] mk);
        int cnt = 0;
        int first = 0;
        for (int i = 0; i < 31; i++) begin
            if (mk[i]) begin
                if (cnt == 0) first = i;
                cnt++;
            end
        end
        if (cnt == 0) return 8'h00;
        if (cnt > 1)  return 8'h30;
        return 8'h31 + 8'(first);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag, input logic [31:0] l, input logic [31:0] mk);
        logic [7:0] v = m_vec(m_raw(l) & mk);
        check({tag, " vector"}, 32'(cpu_vector), 32'(v));
        check({tag, " irq R7"}, 32'(cpu_irq), 32'(v != 8'h00));
        check({tag, " nmi R8"}, 32'(cpu_nmi), 32'(l[30] | l[31]));
    endtask

    task automatic rd(input int word, output logic [31:0] d);
        @(negedge clk);
        bus_rd   = 1'b1;
        bus_addr = 6'(word * 4);
        @(negedge clk);
        bus_rd   = 1'b0;
        d        = bus_rdata;
    endtask

    task automatic wr(input int word, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = 6'(word * 4);
        bus_wdata = d;
        if (word == 0) cur_mask = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_lines(input logic [31:0] l);
        @(negedge clk);
        irq_lines = l;
        @(negedge clk);
    endtask

    task automatic chk_regs(input string tag, input logic [31:0] l);
        logic [31:0] d;
        rd(0, d);  check({tag, " mask R2"}, d, cur_mask);
        rd(1, d);  check({tag, " raw R3"}, d, m_raw(l));
        rd(2, d);  check({tag, " masked R4"}, d, m_raw(l) & cur_mask);
        rd(3, d);  check({tag, " nmi word R8"}, d, l & 32'hC000_0000);
        rd(4, d);  check({tag, " reserved R9"}, d, 32'h0);
        rd(11, d); check({tag, " beyond R9"}, d, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq", 32'(cpu_irq), 0);
        check("R1 vector", 32'(cpu_vector), 0);
        check("R1 nmi", 32'(cpu_nmi), 0);
        chk_regs("R1", 32'h0);

        // R2: mask write then ignored writes elsewhere
        wr(0, 32'hFFFF_FFFF);
        rd(0, d); check("R2 mask load", d, 32'hFFFF_FFFF);
        for (int w = 1; w < 16; w++) begin
            wr(w, 32'h0);
            rd(0, d); check("R2 stray write", d, 32'hFFFF_FFFF);
        end

        // R3/R5/R8: every single line
        for (int n = 0; n < 32; n++) begin
            set_lines(32'h1 << n);
            chk_out("R5 single", irq_lines, cur_mask);
            chk_regs("R3 single", irq_lines);
        end

        // R6: every pair of ordinary lines
        for (int a = 1; a < 30; a++) begin
            for (int b = a + 1; b < 30; b++) begin
                set_lines((32'h1 << a) | (32'h1 << b));
                chk_out("R6 pair", irq_lines, cur_mask);
            end
        end

        // R2 stray write with active sources leaves outputs alone
        set_lines(32'h0000_0010);
        wr(2, 32'h0);
        chk_out("R2 stray outputs", irq_lines, cur_mask);

        // R4/R5/R7/R10: one-hot mask sweep with all ordinary lines high
        set_lines(32'h3FFF_FFFE);
        for (int b = 0; b < 32; b++) begin
            wr(0, 32'h1 << b);
            chk_out("R10 mask write", irq_lines, cur_mask);
            rd(2, d); check("R4 masked onehot", d, m_raw(irq_lines) & cur_mask);
        end
        wr(0, 32'h0);
        chk_out("R7 mask off", irq_lines, cur_mask);

        // R8: NMI lines ignore mask and raw path
        set_lines(32'hC000_0000);
        chk_out("R8 both nmi", irq_lines, cur_mask);
        chk_regs("R8 both nmi", irq_lines);

        // Mixed pseudo-random patterns
        for (int k = 0; k < 300; k++) begin
            logic [31:0] l, mk;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            mk = seed;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            l = (k % 3 == 0) ? (seed & (seed >> 7) & (seed >> 3)) : seed;
            wr(0, mk);
            set_lines(l);
            chk_out("R10 random", l, mk);
            if (k % 10 == 0) chk_regs("R4 random", l);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule